// File: doc/BRIEF.md
# Dual-ID Two-Wire Slave Controller

This block is the serial front end of a data-logging companion chip. It listens on a two-wire bus, using the SCL and SDA lines sampled by the core clock, and answers two separate device identities. One identity reaches a 32K x 8 byte memory through a 15-bit address counter. The other reaches a nine-entry clock and control register file through a 4-bit counter of its own. Both identities share one shift engine. Each counter keeps its last value while the other identity is in use, so software can move between the memory and the clock without setting the memory address again.

A transfer starts with a slave address byte. That byte holds a 4-bit device type, three bits that must match the strap pins, and a read flag. A memory write then carries two address bytes. A register write carries one. After that, data bytes stream with no limit and the counter steps after every byte. A read returns data from the current counter position. The array side sees a plain parallel port for each target: the address, a single-cycle write strobe with its data, and a single-cycle read strobe with data returned combinationally. SDA is driven only as an open-drain pull-down enable.

Top module: `dual_id_twi_slave`

## Requirements
- R1: After reset the block is idle, does not pull SDA (`sda_oe_o` = 0), and both counters are 0. A start (SDA falling while SCL is high) begins a new slave address phase. A stop (SDA rising while SCL is high) returns the block to idle.
- R2: The slave address byte is {type[3:0], strap[2:0], read}, sent MSB first. Type 4'b1010 selects the memory and 4'b1101 selects the registers. The block acknowledges by pulling SDA low for the ninth clock only when the type is one of these two and bits 3:1 equal `strap_i`. On any other address it leaves SDA released and ignores the bus until the next start.
- R3: A memory write sends two address bytes, high byte first. Bits 14:8 of the counter come from bits 6:0 of the high byte, and bit 7 of the high byte is ignored.
- R4: Each data byte of a write is acknowledged. It is written with one `*_we_o` pulse at the current counter position, and the counter then steps. Any number of bytes may follow each other.
- R5: The memory counter wraps from 7FFFh to 0000h.
- R6: A register write sends one address byte. Values 0 to 8 are acknowledged and loaded into the register counter. Any larger value gets no acknowledge, leaves the counter unchanged, and sends the block to idle. The register counter wraps from 8 to 0.
- R7: A read with no address phase returns the byte at the selected counter, MSB first, and steps the counter after each byte. Reading continues while the master acknowledges and ends at a master NACK.
- R8: The two counters are independent. A transfer to one identity leaves the other counter unchanged.
- R9: While `pwr_fail_i` is high the block never pulls SDA and never issues a write strobe.
- R10: A stop or a repeated start in the middle of a byte throws away the partial byte without writing it. A repeated start begins a fresh slave address phase.
- R11: Incoming bits are taken at the SCL rising edge. SDA output changes only after an SCL falling edge, so it is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 3 | Board strap bits matched against the slave address |
| pwr_fail_i | input | 1 | Supply below trip point; bus ignored |
| mem_addr_o | output | 15 | Memory counter / array address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe, one cycle |
| mem_re_o | output | 1 | Memory read strobe, one cycle |
| mem_rdata_i | input | 8 | Memory read data, combinational from address |
| rtc_addr_o | output | 4 | Register counter / register index |
| rtc_wdata_o | output | 8 | Register write data |
| rtc_we_o | output | 1 | Register write strobe, one cycle |
| rtc_re_o | output | 1 | Register read strobe, one cycle |
| rtc_rdata_i | input | 8 | Register read data, combinational from index |

## Verification
The bench aims at the counter wrap points: 7FFFh to 0000h for memory and 8 to 0 for the registers. A design with a wrong wrap would write the second byte to an unexpected location, and the following current-address read would return the wrong byte. It moves between the two identities and then reads without an address phase, which exposes a design whose counters are shared or clobbered. It sends an ignored top address bit, an illegal register index, mismatched straps and types, power-fail traffic, and stops or repeated starts in the middle of a byte. A design that mishandled these would acknowledge when it should not, or would leave a stray byte or a moved counter that a later read reveals.

// File: rtl/dual_id_pkg.sv
`timescale 1ns/1ps
package dual_id_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_RADR,
    ST_WDAT,
    ST_RDAT
  } twi_state_e;
endpackage

// File: rtl/twi_line_sense.sv
`timescale 1ns/1ps
module twi_line_sense #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_m, sda_m;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_m <= '1;
      sda_m <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= {scl_m[SYNC-2:0], scl_i};
      sda_m <= {sda_m[SYNC-2:0], sda_i};
      scl_p <= scl_m[SYNC-1];
      sda_p <= sda_m[SYNC-1];
    end
  end

  assign scl_o   = scl_m[SYNC-1];
  assign sda_o   = sda_m[SYNC-1];
  assign rise_o  = scl_o & ~scl_p;
  assign fall_o  = ~scl_o & scl_p;
  // data edges while the clock stays high mark bus framing
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/twi_addr_ctr.sv
`timescale 1ns/1ps
module twi_addr_ctr #(
  parameter int W    = 15,
  parameter int LAST = (1 << W) - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  generate
    if (LAST == (1 << W) - 1) begin : g_natural
      assign nxt = q_o + W'(1);
    end else begin : g_modulo
      assign nxt = (q_o == W'(LAST)) ? '0 : q_o + W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= nxt;
  end

  // R5 (memory) and R6 (registers): step past the last index lands on zero
  a_r5_ctr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && q_o == W'(LAST)) |=> (q_o == '0));
  a_r6_ctr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= W'(LAST));
endmodule

// File: rtl/dual_id_twi_slave.sv
`timescale 1ns/1ps
module dual_id_twi_slave
  import dual_id_pkg::*;
#(
  parameter logic [3:0] MEM_TYPE = 4'b1010,
  parameter logic [3:0] RTC_TYPE = 4'b1101,
  parameter int         MEM_AW   = 15,
  parameter int         REG_AW   = 4,
  parameter int         REG_LAST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              pwr_fail_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [REG_AW-1:0] rtc_addr_o,
  output logic [7:0]        rtc_wdata_o,
  output logic              rtc_we_o,
  output logic              rtc_re_o,
  input  logic [7:0]        rtc_rdata_i
);
  localparam int HI_W = MEM_AW - 8;

  logic scl_s, sda_s, rise_s, fall_s, start_s, stop_s;

  twi_line_sense #(.SYNC(2)) u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(rise_s), .fall_o(fall_s),
    .start_o(start_s), .stop_o(stop_s)
  );

  twi_state_e      st;
  logic [3:0]      bit_cnt;
  logic [6:0]      sh;
  logic [HI_W-1:0] hi_q;
  logic [7:0]      tx_sh;
  logic            sel_rtc, ack_pend, ack_drv, tx_en, load_q;

  logic [7:0] byte_in;
  logic       byte_done, load_now, dev_hit, rtc_hit, reg_ok;

  assign byte_in   = {sh, sda_s};
  assign byte_done = rise_s && (bit_cnt == 4'd7) && (st != ST_IDLE) && !pwr_fail_i;
  assign load_now  = fall_s && (bit_cnt == 4'd0) && load_q && (st == ST_RDAT) && !pwr_fail_i;
  assign rtc_hit   = (byte_in[7:4] == RTC_TYPE);
  assign dev_hit   = ((byte_in[7:4] == MEM_TYPE) || rtc_hit) && (byte_in[3:1] == strap_i);
  assign reg_ok    = (byte_in <= 8'(REG_LAST));

  assign mem_we_o    = byte_done && (st == ST_WDAT) && !sel_rtc;
  assign rtc_we_o    = byte_done && (st == ST_WDAT) && sel_rtc;
  assign mem_wdata_o = byte_in;
  assign rtc_wdata_o = byte_in;
  assign mem_re_o    = load_now && !sel_rtc;
  assign rtc_re_o    = load_now && sel_rtc;
  assign sda_oe_o    = ack_drv | (tx_en & ~tx_sh[7]);

  twi_addr_ctr #(.W(MEM_AW)) u_mem_ctr (
    .clk_i, .rst_ni,
    .load_i    (byte_done && (st == ST_ALO)),
    .load_val_i({hi_q, byte_in}),
    .inc_i     (mem_we_o | mem_re_o),
    .q_o       (mem_addr_o)
  );

  twi_addr_ctr #(.W(REG_AW), .LAST(REG_LAST)) u_rtc_ctr (
    .clk_i, .rst_ni,
    .load_i    (byte_done && (st == ST_RADR) && reg_ok),
    .load_val_i(byte_in[REG_AW-1:0]),
    .inc_i     (rtc_we_o | rtc_re_o),
    .q_o       (rtc_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE;  bit_cnt <= '0;  sh <= '0;  hi_q <= '0;  tx_sh <= '0;
      sel_rtc <= 1'b0;  ack_pend <= 1'b0;  ack_drv <= 1'b0;  tx_en <= 1'b0;  load_q <= 1'b0;
    end else if (pwr_fail_i || stop_s || start_s) begin
      // framing, or loss of supply, drops any partial byte
      st <= (start_s && !pwr_fail_i) ? ST_DEV : ST_IDLE;
      bit_cnt <= '0;  ack_pend <= 1'b0;  ack_drv <= 1'b0;  tx_en <= 1'b0;  load_q <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (rise_s) begin
        if (bit_cnt == 4'd8) begin
          bit_cnt <= '0;
          if (st == ST_RDAT) begin
            if (sda_s) st <= ST_IDLE;   // master NACK ends the read
            else       load_q <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 4'd1;
          sh      <= {sh[5:0], sda_s};
          if (bit_cnt == 4'd7) begin
            ack_pend <= 1'b1;
            case (st)
              ST_DEV: begin
                if (dev_hit) begin
                  sel_rtc <= rtc_hit;
                  if (byte_in[0]) begin
                    st <= ST_RDAT;
                    load_q <= 1'b1;
                  end else begin
                    st <= rtc_hit ? ST_RADR : ST_AHI;
                  end
                end else begin
                  st <= ST_IDLE;
                  ack_pend <= 1'b0;
                end
              end
              ST_AHI: begin
                hi_q <= byte_in[HI_W-1:0];
                st   <= ST_ALO;
              end
              ST_ALO: st <= ST_WDAT;
              ST_RADR: begin
                if (reg_ok) st <= ST_WDAT;
                else begin
                  st <= ST_IDLE;
                  ack_pend <= 1'b0;
                end
              end
              ST_WDAT: ;
              default: ack_pend <= 1'b0;
            endcase
          end
        end
      end
      if (fall_s) begin
        if (bit_cnt == 4'd8) begin
          ack_drv  <= ack_pend;
          ack_pend <= 1'b0;
          tx_en    <= 1'b0;
        end else if (bit_cnt == 4'd0) begin
          ack_drv <= 1'b0;
          if (load_now) begin
            tx_en  <= 1'b1;
            tx_sh  <= sel_rtc ? rtc_rdata_i : mem_rdata_i;
            load_q <= 1'b0;
          end
        end else if (st == ST_RDAT) begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  // R9: a power-fail cycle leaves the line released and no write behind it
  a_r9_release_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !sda_oe_o);
  a_r9_no_write_after_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || rtc_we_o) |-> !$past(pwr_fail_i));
  // R11: the pull-down only engages while the sampled clock is low
  a_r11_drive_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
  // R4: at most one array strobe per cycle
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, rtc_we_o, mem_re_o, rtc_re_o}));
endmodule

// File: tb/dual_id_twi_slave_bench.sv
`timescale 1ns/1ps
module dual_id_twi_slave_bench;
  localparam int QTR = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0;
  always #2.5 clk = ~clk;

  logic        sda_oe, mem_we, mem_re, rtc_we, rtc_re;
  logic [14:0] mem_addr;
  logic [3:0]  rtc_addr;
  logic [7:0]  mem_wdata, rtc_wdata, mem_rdata, rtc_rdata;
  logic        sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  logic [7:0] dut_mem [0:32767];
  logic [7:0] dut_rtc [0:15];
  logic [7:0] ref_mem [0:32767];
  logic [7:0] ref_rtc [0:8];
  int ref_mptr = 0, ref_rptr = 0;
  assign mem_rdata = dut_mem[mem_addr];
  assign rtc_rdata = dut_rtc[rtc_addr];
  always @(posedge clk) begin
    if (mem_we) dut_mem[mem_addr] <= mem_wdata;
    if (rtc_we) dut_rtc[rtc_addr] <= rtc_wdata;
  end

  dual_id_twi_slave u_dual_id_twi_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .pwr_fail_i(pwr_fail),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_rdata_i(mem_rdata),
    .rtc_addr_o(rtc_addr), .rtc_wdata_o(rtc_wdata), .rtc_we_o(rtc_we), .rtc_re_o(rtc_re),
    .rtc_rdata_i(rtc_rdata)
  );

  int errors = 0, checks = 0, hi_changes = 0;
  bit done = 1'b0;
  logic scl_d = 1'b1, oe_d = 1'b0;

  // R11 monitor: the design's pull-down must hold still while SCL stays high
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_d && (sda_oe !== oe_d)) hi_changes++;
    scl_d = scl_m;
    oe_d  = sda_oe;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = !sda_bus;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv(output logic [7:0] b, input bit ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = !ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(bit rtc, bit rd);
    return {rtc ? 4'b1101 : 4'b1010, STRAP, rd};
  endfunction

  function automatic logic [7:0] pick(int k, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    return (k == 0) ? b0 : (k == 1) ? b1 : b2;
  endfunction

  task automatic addr_phase(bit rtc, logic [15:0] a, string tag);
    bit ak;
    send(dev(rtc, 1'b0), ak); chk({tag, " R2 address ack"}, ak, 1);
    if (rtc) begin
      send(a[7:0], ak); chk({tag, " R6 index ack"}, ak, 1);
      ref_rptr = a;
    end else begin
      send(a[15:8], ak); chk({tag, " R3 high ack"}, ak, 1);
      send(a[7:0], ak);  chk({tag, " R3 low ack"}, ak, 1);
      ref_mptr = a & 16'h7fff;
    end
  endtask

  task automatic wr(bit rtc, logic [15:0] a, int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, string tag);
    bit ak;
    logic [7:0] d;
    bus_start();
    addr_phase(rtc, a, tag);
    for (int k = 0; k < n; k++) begin
      d = pick(k, b0, b1, b2);
      send(d, ak); chk({tag, " R4 data ack"}, ak, 1);
      if (rtc) begin
        ref_rtc[ref_rptr] = d;
        ref_rptr = (ref_rptr == 8) ? 0 : ref_rptr + 1;
      end else begin
        ref_mem[ref_mptr] = d;
        ref_mptr = (ref_mptr + 1) & 32'h7fff;
      end
    end
    bus_stop();
  endtask

  task automatic rd_body(bit rtc, int n, string tag);
    bit ak;
    logic [7:0] d;
    bus_start();
    send(dev(rtc, 1'b1), ak); chk({tag, " R2 read ack"}, ak, 1);
    for (int k = 0; k < n; k++) begin
      recv(d, k != n - 1);
      if (rtc) begin
        chk({tag, " R7 register data"}, d, ref_rtc[ref_rptr]);
        ref_rptr = (ref_rptr == 8) ? 0 : ref_rptr + 1;
      end else begin
        chk({tag, " R7 memory data"}, d, ref_mem[ref_mptr]);
        ref_mptr = (ref_mptr + 1) & 32'h7fff;
      end
    end
    bus_stop();
  endtask

  task automatic rd_at(logic [15:0] a, int n, string tag);
    bus_start();
    addr_phase(1'b0, a, tag);
    rd_body(1'b0, n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ak;
    for (int i = 0; i < 32768; i++) begin dut_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
    for (int i = 0; i < 16; i++) dut_rtc[i] = 8'h00;
    for (int i = 0; i < 9; i++) ref_rtc[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset mem counter", mem_addr, 0);
    chk("R1 reset reg counter", rtc_addr, 0);

    // R3/R4/R7 streaming write then addressed read
    wr(1'b0, 16'h0010, 3, 8'h11, 8'h22, 8'h33, "burst");
    chk("R4 array 0x12", dut_mem[16'h12], 8'h33);
    rd_at(16'h0010, 3, "burst");

    // R3 top address bit ignored
    wr(1'b0, 16'h8020, 1, 8'h5a, 0, 0, "msb");
    chk("R3 bit15 ignored", dut_mem[16'h20], 8'h5a);

    // R5 memory wrap
    wr(1'b0, 16'h7fff, 2, 8'ha1, 8'hb2, 0, "wrap");
    chk("R5 last byte", dut_mem[16'h7fff], 8'ha1);
    chk("R5 wrapped byte", dut_mem[0], 8'hb2);
    rd_body(1'b0, 1, "wrap");

    // R6 register stream with wrap 8 -> 0
    wr(1'b1, 16'h0007, 3, 8'h70, 8'h80, 8'h90, "regs");
    chk("R6 reg 8", dut_rtc[8], 8'h80);
    chk("R6 reg 0 after wrap", dut_rtc[0], 8'h90);
    rd_body(1'b1, 2, "regs");

    // R8 independent counters
    wr(1'b0, 16'h0101, 1, 8'h77, 0, 0, "indep");
    wr(1'b0, 16'h0100, 1, 8'hc3, 0, 0, "indep");
    wr(1'b1, 16'h0002, 1, 8'h44, 0, 0, "indep");
    chk("R8 memory counter kept", mem_addr, 16'h0101);
    rd_body(1'b0, 1, "R8 mem after reg");
    rd_body(1'b1, 1, "R8 reg after mem");

    // R6 illegal register index
    bus_start();
    send(dev(1'b1, 1'b0), ak); chk("R6 illegal frame addr ack", ak, 1);
    send(8'h09, ak);            chk("R6 illegal index nack", ak, 0);
    bus_stop();
    chk("R6 counter unchanged", rtc_addr, ref_rptr);
    rd_body(1'b1, 1, "R6 after illegal");

    // R2 mismatches
    bus_start();
    send({4'b1010, 3'b001, 1'b0}, ak); chk("R2 strap mismatch nack", ak, 0);
    send(8'h00, ak);                   chk("R2 ignored after mismatch", ak, 0);
    bus_stop();
    bus_start();
    send({4'b1111, STRAP, 1'b0}, ak);  chk("R2 type mismatch nack", ak, 0);
    bus_stop();

    // R9 power fail
    pwr_fail = 1'b1;
    bus_start();
    send(dev(1'b0, 1'b0), ak); chk("R9 no ack in fail", ak, 0);
    send(8'h04, ak); send(8'h00, ak); send(8'hee, ak);
    chk("R9 no data ack", ak, 0);
    bus_stop();
    chk("R9 nothing written", dut_mem[16'h0400], 8'h00);
    pwr_fail = 1'b0;
    wq();

    // R10 stop mid-byte
    wr(1'b0, 16'h0200, 1, 8'h12, 0, 0, "abort");
    bus_start();
    addr_phase(1'b0, 16'h0200, "abort");
    send_bits(8'hee, 5);
    bus_stop();
    chk("R10 stop keeps byte", dut_mem[16'h0200], 8'h12);
    rd_body(1'b0, 1, "R10 stop");

    // R10 repeated start mid-byte
    wr(1'b0, 16'h0300, 1, 8'h34, 0, 0, "restart");
    bus_start();
    addr_phase(1'b0, 16'h0300, "restart");
    send_bits(8'h00, 3);
    bus_start();
    addr_phase(1'b0, 16'h0310, "restart");
    send(8'h99, ak); chk("R10 new frame data ack", ak, 1);
    ref_mem[16'h0310] = 8'h99; ref_mptr = 16'h0311;
    bus_stop();
    chk("R10 restart keeps byte", dut_mem[16'h0300], 8'h34);
    chk("R10 new frame byte", dut_mem[16'h0310], 8'h99);
    rd_at(16'h0300, 1, "R10 restart");

    chk("R11 sda steady while SCL high", hi_changes, 0);
    chk("R1 idle release", sda_oe, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule